// File: doc/BRIEF.md
# Bus Master Target-Termination Handler

This block is the sequencing core of a master on a PCI-style parallel bus. A client asks it to move a run of words that starts at a word address. The block then requests the bus and waits for a grant. It drives one address phase and then holds data phases open until the target accepts each word. It also watches the target's response lines, so it sees when the target ends the cycle early.

Three kinds of early termination are handled:

- **Disconnect with data:** the target stops and still takes the word on that clock.
- **Disconnect without data:** the target stops and takes nothing.
- **Target abort:** the target raises stop with its select line low.

After either disconnect the block winds down in a fixed order. It drops frame first, then ready, then gives up the bus. It then waits a fixed gap before it asks for the bus again, and the new burst starts at the first word not yet accepted. After a target abort, or when no target claims the cycle in time, the block gives up the rest of the run and raises a one-cycle error flag.

All bus lines in this description are active high: a value of 1 means asserted. Addresses count words and grow by one for each accepted word. Parity, data storage and configuration space belong to other blocks.

Top module: `bm_term_master`

## Requirements
- R1: While reset is held and just after it, req_o, frame_o, irdy_o, own_o, busy_o, done_o, tabort_o and mabort_o are all 0.
- R2: A start_i pulse in idle with a nonzero word count raises req_o on the next cycle. A start_i with a count of 0 is ignored: the block stays idle with req_o at 0.
- R3: req_o stays at 1 until gnt_i is sampled at 1. The next cycle is an address phase: addr_phase_o and frame_o are 1, irdy_o is 0, and bus_addr_o holds the first untransferred word address. The cycle after that is the first data phase.
- R4: During a data phase (frame_o and irdy_o both 1), a clock with devsel_i at 1 and both trdy_i and stop_i at 0 is a wait state. frame_o and irdy_o both stay at 1 on the next cycle.
- R5: A word counts as transferred on every clock where frame_o, irdy_o and trdy_i are all 1, including a clock where stop_i is also 1. Each such word adds one to words_done_o and one to the word address.
- R6: After the burst ends, the line changes come one per cycle. On the first cycle frame_o is 0 and irdy_o is 1. On the second cycle irdy_o is 0 and own_o is still 1. On the third cycle own_o is 0.
- R7: Any of three events ends the burst: stop_i, a master-abort timeout, or the transfer of the last word. When stop_i is sampled with devsel_i at 1 (a disconnect, with or without data) and words remain, req_o stays 0 for exactly GAP_CYCLES cycles after own_o falls and then rises. The next address phase carries the address of the first word that was not transferred.
- R8: A target abort is stop_i at 1 with devsel_i at 0. It ends the run with no retry. tabort_o pulses for one cycle in the cycle own_o falls, done_o stays 0, and the block returns to idle.
- R9: If devsel_i is 0 on DEVSEL_WAIT consecutive data-phase clocks counted from the first one, the burst ends through the R6 sequence. mabort_o then pulses for one cycle in the cycle own_o falls, and the run is dropped.
- R10: When the last word is transferred, done_o pulses for one cycle in the cycle own_o falls, busy_o goes to 0 and words_done_o equals the requested count. This holds whether the burst ends by completion or by a disconnect with data.
- R11: A start_i pulse while busy_o is 1 is ignored and does not change the addresses or counts of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (accepted only in idle) |
| start_addr_i | input | ADDR_W | First word address of the run |
| word_cnt_i | input | CNT_W | Number of words in the run |
| gnt_i | input | 1 | Bus grant |
| devsel_i | input | 1 | Target has claimed the cycle |
| trdy_i | input | 1 | Target ready for the data phase |
| stop_i | input | 1 | Target requests termination |
| req_o | output | 1 | Bus request |
| frame_o | output | 1 | Cycle frame |
| irdy_o | output | 1 | Master ready |
| own_o | output | 1 | Master currently drives the bus |
| addr_phase_o | output | 1 | Address phase in progress |
| bus_addr_o | output | ADDR_W | Next untransferred word address |
| words_done_o | output | CNT_W | Words transferred in this run |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: run completed |
| tabort_o | output | 1 | One-cycle pulse: target abort |
| mabort_o | output | 1 | One-cycle pulse: master abort |

## Verification
The assertions check the following on every cycle:

- the order in which frame, ready and bus ownership fall;
- that a wait state holds the data phase open;
- that a grant leads into an address phase;
- that request stays low when the bus is released;
- that the address moves by one for each accepted word;
- that at most one end-of-run flag is raised at a time.

Some behaviour shows only in the bench's scenarios, because it depends on the whole run. This covers the exact length of the re-request gap and the address of a resumed burst after a disconnect with or without data. It also covers the final word counts, the dropping of the rest of a run after either abort, and the rejection of a start that arrives mid-run or carries a zero count.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_ADDR,
        ST_DATA,
        ST_FR_OFF,
        ST_IR_OFF,
        ST_HOLD
    } bm_state_e;

    typedef enum logic [1:0] {
        END_COMPLETE,
        END_DISC,
        END_TABORT,
        END_MABORT
    } bm_end_e;

    typedef struct packed {
        logic devsel;
        logic trdy;
        logic stop;
    } tgt_resp_t;

    typedef struct packed {
        logic req;
        logic frame;
        logic irdy;
        logic own;
        logic addr_ph;
    } bus_drive_t;

    // Kind of early end when the target raises stop
    function automatic bm_end_e stop_kind(tgt_resp_t r);
        return r.devsel ? END_DISC : END_TABORT;
    endfunction

    // Bus line levels decoded from the state
    function automatic bus_drive_t drive_of(bm_state_e s);
        bus_drive_t d;
        d.req     = (s == ST_ARB);
        d.frame   = (s == ST_ADDR) || (s == ST_DATA);
        d.irdy    = (s == ST_DATA) || (s == ST_FR_OFF);
        d.own     = (s == ST_ADDR) || (s == ST_DATA) || (s == ST_FR_OFF) || (s == ST_IR_OFF);
        d.addr_ph = (s == ST_ADDR);
        return d;
    endfunction

endpackage

// File: rtl/bmt_word_track.sv
module bmt_word_track #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [CNT_W-1:0]  load_cnt_i,
    input  logic              xfer_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  words_o,
    output logic              last_word_o,
    output logic              remain_zero_o
);
    localparam logic [CNT_W-1:0] ONE_W = CNT_W'(1);

    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic [CNT_W-1:0]  words;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            remain   <= '0;
            words    <= '0;
        end else if (load_i) begin
            cur_addr <= load_addr_i;
            remain   <= load_cnt_i;
            words    <= '0;
        end else if (xfer_i) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            remain   <= remain - ONE_W;
            words    <= words + ONE_W;
        end
    end

    assign cur_addr_o    = cur_addr;
    assign words_o       = words;
    assign last_word_o   = (remain == ONE_W);
    assign remain_zero_o = (remain == '0);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && !load_i) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1))); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        xfer_i |-> (remain != '0)); // R5

endmodule

// File: rtl/bmt_holdoff.sv
module bmt_holdoff #(
    parameter int GAP_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic active_i,
    output logic expire_o
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] START_V = GW'(GAP_CYCLES - 1);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= START_V;
        end else if (active_i && cnt != '0) begin
            cnt <= cnt - GW'(1);
        end
    end

    assign expire_o = active_i && (cnt == '0);

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        active_i |-> (cnt <= START_V)); // R7

endmodule

// File: rtl/bmt_devsel_wd.sv
module bmt_devsel_wd #(
    parameter int DEVSEL_WAIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    input  logic devsel_i,
    output logic timeout_o
);
    localparam int DW = $clog2(DEVSEL_WAIT + 1);
    localparam logic [DW-1:0] LIMIT = DW'(DEVSEL_WAIT - 1);

    logic [DW-1:0] cnt;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (run_i) begin
            if (devsel_i) begin
                seen <= 1'b1;
            end else if (!seen && cnt != LIMIT) begin
                cnt <= cnt + DW'(1);
            end
        end
    end

    assign timeout_o = run_i && !seen && !devsel_i && (cnt == LIMIT);

    AST_DSEL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (run_i && !seen) |-> (cnt <= LIMIT)); // R9

endmodule

// File: rtl/bmt_fsm.sv
module bmt_fsm
    import bmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      cnt_nonzero_i,
    input  logic      gnt_i,
    input  tgt_resp_t resp_i,
    input  logic      last_word_i,
    input  logic      remain_zero_i,
    input  logic      hold_expire_i,
    input  logic      dsel_timeout_i,
    output bm_state_e state_o,
    output logic      accept_o,
    output logic      xfer_o,
    output logic      hold_load_o,
    output logic      done_o,
    output logic      tabort_o,
    output logic      mabort_o
);
    bm_state_e st, nxt;
    bm_end_e   term, nterm;
    logic      fin;
    logic      done_q, tabort_q, mabort_q;

    always_comb begin
        nxt   = st;
        nterm = term;
        case (st)
            ST_IDLE:   if (start_i && cnt_nonzero_i) nxt = ST_ARB;
            ST_ARB:    if (gnt_i) nxt = ST_ADDR;
            ST_ADDR:   nxt = ST_DATA;
            ST_DATA: begin
                if (resp_i.stop) begin
                    nxt   = ST_FR_OFF;
                    nterm = stop_kind(resp_i);
                end else if (dsel_timeout_i) begin
                    nxt   = ST_FR_OFF;
                    nterm = END_MABORT;
                end else if (resp_i.trdy && last_word_i) begin
                    nxt   = ST_FR_OFF;
                    nterm = END_COMPLETE;
                end
            end
            ST_FR_OFF: nxt = ST_IR_OFF;
            ST_IR_OFF: nxt = (term == END_DISC && !remain_zero_i) ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (hold_expire_i) nxt = ST_ARB;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign fin = (st == ST_IR_OFF) && (nxt == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            term     <= END_COMPLETE;
            done_q   <= 1'b0;
            tabort_q <= 1'b0;
            mabort_q <= 1'b0;
        end else begin
            st       <= nxt;
            term     <= nterm;
            done_q   <= fin && (term == END_COMPLETE || term == END_DISC);
            tabort_q <= fin && (term == END_TABORT);
            mabort_q <= fin && (term == END_MABORT);
        end
    end

    assign state_o     = st;
    assign accept_o    = (st == ST_IDLE) && start_i && cnt_nonzero_i;
    assign xfer_o      = (st == ST_DATA) && resp_i.trdy;
    assign hold_load_o = (st == ST_IR_OFF);
    assign done_o      = done_q;
    assign tabort_o    = tabort_q;
    assign mabort_o    = mabort_q;

    AST_ONE_END_FLAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_q, tabort_q, mabort_q})); // R8
    AST_ABORT_NO_RETRY: assert property (@(posedge clk) disable iff (rst)
        (tabort_q || mabort_q) |-> (st == ST_IDLE)); // R8

endmodule

// File: rtl/bm_term_master.sv
module bm_term_master
    import bmt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 8,
    parameter int DEVSEL_WAIT = 4,
    parameter int GAP_CYCLES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic              gnt_i,
    input  logic              devsel_i,
    input  logic              trdy_i,
    input  logic              stop_i,
    output logic              req_o,
    output logic              frame_o,
    output logic              irdy_o,
    output logic              own_o,
    output logic              addr_phase_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [CNT_W-1:0]  words_done_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              tabort_o,
    output logic              mabort_o
);
    bm_state_e  st;
    tgt_resp_t  resp;
    bus_drive_t drv;
    logic       accept, xfer, hold_load, hold_expire, dsel_timeout;
    logic       last_word, remain_zero;

    assign resp.devsel = devsel_i;
    assign resp.trdy   = trdy_i;
    assign resp.stop   = stop_i;

    bmt_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .cnt_nonzero_i  (word_cnt_i != '0),
        .gnt_i          (gnt_i),
        .resp_i         (resp),
        .last_word_i    (last_word),
        .remain_zero_i  (remain_zero),
        .hold_expire_i  (hold_expire),
        .dsel_timeout_i (dsel_timeout),
        .state_o        (st),
        .accept_o       (accept),
        .xfer_o         (xfer),
        .hold_load_o    (hold_load),
        .done_o         (done_o),
        .tabort_o       (tabort_o),
        .mabort_o       (mabort_o)
    );

    bmt_word_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
        .clk           (clk),
        .rst           (rst),
        .load_i        (accept),
        .load_addr_i   (start_addr_i),
        .load_cnt_i    (word_cnt_i),
        .xfer_i        (xfer),
        .cur_addr_o    (bus_addr_o),
        .words_o       (words_done_o),
        .last_word_o   (last_word),
        .remain_zero_o (remain_zero)
    );

    bmt_holdoff #(.GAP_CYCLES(GAP_CYCLES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load_i   (hold_load),
        .active_i (st == ST_HOLD),
        .expire_o (hold_expire)
    );

    bmt_devsel_wd #(.DEVSEL_WAIT(DEVSEL_WAIT)) u_wd (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (st == ST_ADDR),
        .run_i     (st == ST_DATA),
        .devsel_i  (devsel_i),
        .timeout_o (dsel_timeout)
    );

    assign drv          = drive_of(st);
    assign req_o        = drv.req;
    assign frame_o      = drv.frame;
    assign irdy_o       = drv.irdy;
    assign own_o        = drv.own;
    assign addr_phase_o = drv.addr_ph;
    assign busy_o       = (st != ST_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_o && !gnt_i) |=> req_o); // R3
    AST_GNT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (req_o && gnt_i) |=> (addr_phase_o && frame_o && !irdy_o)); // R3
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frame_o && irdy_o && devsel_i && !trdy_i && !stop_i) |=> (frame_o && irdy_o)); // R4
    AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_o) |-> irdy_o); // R6
    AST_IRDY_NEXT: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_o) |=> (!irdy_o && own_o)); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(irdy_o) |=> !own_o); // R6
    AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(own_o) |-> !req_o); // R7
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (tabort_o || mabort_o) |-> (!busy_o && !done_o)); // R9

endmodule

// File: tb/sim_bm_term_master.sv
module sim_bm_term_master;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int DW = 4;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          start = 1'b0;
    logic [AW-1:0] sa = '0;
    logic [CW-1:0] sc = '0;
    logic          gnt = 1'b0, devsel = 1'b0, trdy = 1'b0, stop = 1'b0;
    logic          req_o, frame_o, irdy_o, own_o, addr_phase_o, busy_o;
    logic          done_o, tabort_o, mabort_o;
    logic [AW-1:0] bus_addr_o;
    logic [CW-1:0] words_done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    bm_term_master #(.ADDR_W(AW), .CNT_W(CW), .DEVSEL_WAIT(DW), .GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .start_addr_i(sa), .word_cnt_i(sc),
        .gnt_i(gnt), .devsel_i(devsel), .trdy_i(trdy), .stop_i(stop),
        .req_o(req_o), .frame_o(frame_o), .irdy_o(irdy_o), .own_o(own_o),
        .addr_phase_o(addr_phase_o), .bus_addr_o(bus_addr_o), .words_done_o(words_done_o),
        .busy_o(busy_o), .done_o(done_o), .tabort_o(tabort_o), .mabort_o(mabort_o)
    );

    task automatic ceq(input string rq, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic nx;
        @(posedge clk);
        @(negedge clk);
    endtask

    // kind of burst end: 0 complete, 1 disconnect, 2 target abort, 3 master abort
    function automatic bit ends_run(input int kind, input int rem);
        return !(kind == 1 && rem > 0);
    endfunction

    // mode: 0 plain, 1 disconnect with data, 2 disconnect without data,
    //       3 target abort, 4 no target claims the cycle
    task automatic do_op(input logic [AW-1:0] a, input int n, input int mode,
                         input int ws, input int dd, input int disc_at, input bit poke);
        logic [AW-1:0] exp_a;
        int rem, words, kind;
        bit disc_pend, fin, first;
        exp_a = a; rem = n; words = 0; kind = 0;
        disc_pend = (mode == 1 || mode == 2 || mode == 3);
        fin = 1'b0; first = 1'b1;
        start = 1'b1; sa = a; sc = CW'(n);
        nx;
        start = 1'b0;
        ceq("R2 req after start", req_o, 1);
        while (!fin) begin
            int gd, clk_i, wc;
            bit ended;
            gd = int'($urandom % 3);
            clk_i = 0; wc = 0; ended = 1'b0;
            for (int i = 0; i < gd; i++) begin
                ceq("R3 req held until grant", {req_o, frame_o}, 2);
                nx;
            end
            gnt = 1'b1;
            nx;
            gnt = 1'b0;
            ceq("R3 address phase", {addr_phase_o, frame_o, irdy_o}, 6);
            ceq("R7 R3 address of first untransferred word", bus_addr_o, exp_a);
            nx;
            while (!ended) begin
                bit dv, tr, sp;
                ceq("R4 data phase open", {frame_o, irdy_o}, 3);
                if (poke && first && clk_i == 0) begin
                    start = 1'b1; sa = 32'hDEAD_0000; sc = 8'd5; // R11 start while busy
                end
                dv = 1'b0; tr = 1'b0; sp = 1'b0;
                if (mode != 4) begin
                    dv = (clk_i >= dd);
                    if (disc_pend && words == disc_at && (mode == 2 || mode == 3)) begin
                        sp = 1'b1; dv = (mode == 2); tr = 1'b0;
                    end else begin
                        tr = dv && (wc >= ws);
                        if (tr && disc_pend && mode == 1 && words == disc_at) sp = 1'b1;
                    end
                end
                devsel = dv; trdy = tr; stop = sp;
                nx;
                start = 1'b0;
                clk_i++;
                if (tr) begin
                    words++; exp_a = exp_a + 1; rem--; wc = 0;
                end else if (dv) begin
                    wc++;
                end
                if (sp) begin
                    ended = 1'b1; kind = dv ? 1 : 2; disc_pend = 1'b0;
                end else if (mode == 4 && clk_i == DW) begin
                    ended = 1'b1; kind = 3;
                end else if (tr && rem == 0) begin
                    ended = 1'b1; kind = 0;
                end
            end
            first = 1'b0;
            devsel = 1'b0; trdy = 1'b0; stop = 1'b0;
            ceq("R6 frame off, irdy on", {frame_o, irdy_o}, 1);
            nx;
            ceq("R6 irdy off, bus still owned", {irdy_o, own_o}, 1);
            nx;
            ceq("R6 bus released", own_o, 0);
            ceq("R5 R11 words counted", words_done_o, words);
            if (!ends_run(kind, rem)) begin
                for (int i = 0; i < GAP; i++) begin
                    ceq("R7 req low during gap", req_o, 0);
                    nx;
                end
                ceq("R7 req after gap", req_o, 1);
            end else begin
                fin = 1'b1;
                ceq("R10 done flag", done_o, (kind <= 1) ? 1 : 0);
                ceq("R8 target abort flag", tabort_o, (kind == 2) ? 1 : 0);
                ceq("R9 master abort flag", mabort_o, (kind == 3) ? 1 : 0);
                ceq("R10 R8 idle after run", {busy_o, req_o}, 0);
                if (kind <= 1) ceq("R10 full count", words_done_o, n);
                nx;
                ceq("R10 flags are one cycle", {done_o, tabort_o, mabort_o}, 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        ceq("R1 reset outputs", {req_o, frame_o, irdy_o, own_o, busy_o, done_o, tabort_o, mabort_o}, 0);
        rst = 1'b0;
        nx;
        ceq("R1 idle after reset", {req_o, frame_o, irdy_o, own_o, busy_o}, 0);
        // R2 zero count is ignored
        start = 1'b1; sa = 32'h100; sc = '0;
        nx;
        start = 1'b0;
        ceq("R2 zero count ignored", {busy_o, req_o}, 0);
        nx;
        ceq("R2 still idle", {busy_o, req_o}, 0);
        // directed corners
        do_op(32'h1000, 3, 0, 0, 0, 0, 1'b0);  // R10 plain run
        do_op(32'h2000, 4, 0, 2, 3, 0, 1'b0);  // R4 wait states, late devsel
        do_op(32'h3000, 5, 1, 0, 0, 1, 1'b1);  // R7 R11 disconnect with data
        do_op(32'h4000, 3, 2, 1, 0, 0, 1'b0);  // R7 disconnect without data at first word
        do_op(32'h5000, 4, 1, 0, 1, 3, 1'b0);  // R10 disconnect on last word
        do_op(32'h6000, 4, 3, 0, 0, 2, 1'b0);  // R8 target abort mid-run
        do_op(32'h7000, 4, 4, 0, 0, 0, 1'b0);  // R9 master abort
        // constrained random runs
        for (int k = 0; k < 40; k++) begin
            int n, md;
            n  = 1 + int'($urandom % 6);
            md = int'($urandom % 5);
            do_op(AW'($urandom), n, md, int'($urandom % 3), int'($urandom % DW),
                  int'($urandom % n), ($urandom % 4) == 0);
            repeat (int'($urandom % 3)) nx;
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule